// File: doc/BRIEF.md
# Downward-Growing Hardware Stack Engine

This block keeps the stack pointer for a small 8-bit controller whose data space is a single byte-addressed map. The low 32 addresses hold the general-purpose registers. The following 480 addresses form an I/O window, made up of 64 standard and 416 extended locations. On-chip SRAM of 8K bytes sits directly above that window, at 0x0200 to 0x21FF. The stack may only live in that SRAM. It begins at its highest byte and grows toward lower addresses.

The instruction decoder presents one operation per cycle:
- A register push stores the supplied byte and then moves the pointer down.
- A register pop moves the pointer up and then loads a byte, which is returned together with the destination register index.
- A subroutine call saves a 16-bit return address as two bytes.
- A return fetches those two bytes back and rebuilds the address.

The block drives a data-memory port whose read data is available in the same cycle. A separate load input lets software place the pointer anywhere inside SRAM.

Top module: `stack_engine`

## Requirements
- R1: After reset the stack pointer reads 0x21FF, the overflow, underflow and busy outputs are low, and the stack pointer never leaves 0x0200..0x21FF.
- R2: A push (op code 1) writes push_data to the address held in the stack pointer, and the pointer is then one lower after that clock edge.
- R3: A push with the stack pointer at 0x0200 performs no memory write, leaves the pointer unchanged and sets the overflow output.
- R4: A pop (op code 2) reads the byte at the stack pointer plus one and raises the pointer by one. One cycle later it presents that byte on pop_data, together with the register index on pop_idx and a one-cycle pop_valid pulse.
- R5: A pop with the stack pointer at 0x21FF performs no read, gives no pop_valid, leaves the pointer unchanged and sets the underflow output.
- R6: A call (op code 3) takes two cycles. It first writes the low byte of ret_in at the pointer, then writes the high byte at the pointer minus one, so the pointer ends two lower. Busy is high during the second cycle.
- R7: A return (op code 4) takes two cycles. It reads the high byte at the pointer plus one and then the low byte at the pointer plus two. It then presents the rebuilt address on ret_addr with a one-cycle ret_valid pulse, and the pointer ends two higher.
- R8: A call with the pointer below 0x0202 writes nothing and sets overflow. A return with the pointer above 0x21FD reads nothing and sets underflow. In both cases the pointer is unchanged and busy stays low.
- R9: Any operation presented while busy is high is ignored: it causes no memory access, no pointer change beyond the running sequence, and no pop_valid.
- R10: A pointer load (sp_we high) takes effect only for values inside 0x0200..0x21FF and is otherwise ignored. When it is accepted or ignored it takes priority over any operation in the same cycle, which then does nothing.
- R11: The overflow and underflow outputs describe the most recently accepted push, pop, call or return, so a successful operation clears a flag left by an earlier failed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation: 0 none, 1 push, 2 pop, 3 call, 4 return |
| reg_idx | input | 5 | Register index carried with a pop |
| push_data | input | 8 | Byte of the selected register, for a push |
| ret_in | input | 16 | Return address saved by a call |
| sp_we | input | 1 | Load the stack pointer from sp_wdata |
| sp_wdata | input | 16 | Value for a pointer load |
| sp | output | 16 | Current stack pointer |
| pop_data | output | 8 | Byte returned by the last pop |
| pop_valid | output | 1 | One-cycle pulse: pop_data and pop_idx are new |
| pop_idx | output | 5 | Destination register of the last pop |
| ret_addr | output | 16 | Address rebuilt by the last return |
| ret_valid | output | 1 | One-cycle pulse: ret_addr is new |
| ovf | output | 1 | Last accepted operation hit the SRAM floor |
| udf | output | 1 | Last accepted operation found the stack empty |
| busy | output | 1 | Second cycle of a call or return |
| mem_addr | output | 16 | Data-memory address |
| mem_we | output | 1 | Data-memory write strobe |
| mem_wdata | output | 8 | Data-memory write byte |
| mem_re | output | 1 | Data-memory read strobe |
| mem_rdata | input | 8 | Data-memory read byte, valid in the same cycle |

## Verification
The push and pop path is exercised with two distinct bytes pushed and then popped. The order in which they come back separates a true last-in-first-out order from a pointer that moves in the wrong direction or changes before the access instead of after it. Calls and returns use an address whose two bytes differ. Checking which SRAM byte holds each half, and the rebuilt value, shows whether the byte order or the read order is swapped. The two edges of SRAM are approached by pointer loads to 0x0200, 0x0201 and 0x0202 and by runs from 0x21FF and 0x21FE, so single-byte and two-byte room checks are each tried exactly at the edge and one byte away. Pushes and pops offered during busy cycles, and in the same cycle as a load, show whether the ignore and priority rules hold, because memory writes are counted and the pointer is observed.

// File: rtl/stk_pkg.sv
package stk_pkg;
    typedef enum logic [2:0] {
        OP_NONE = 3'd0,
        OP_PUSH = 3'd1,
        OP_POP  = 3'd2,
        OP_CALL = 3'd3,
        OP_RET  = 3'd4
    } stk_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_CALL_HI = 2'd1,
        ST_RET_LO  = 2'd2
    } stk_state_e;
endpackage

// File: rtl/stk_room.sv
// Headroom check: is there space for NEED more bytes below the pointer,
// and are there at least NEED bytes stored above it.
module stk_room #(
    parameter int              AW      = 16,
    parameter logic [AW-1:0]   SRAM_LO = 16'h0200,
    parameter logic [AW-1:0]   SRAM_HI = 16'h21FF,
    parameter int              NEED    = 1
) (
    input  logic [AW-1:0] sp_i,
    output logic          can_down_o,
    output logic          can_up_o
);
    localparam int LO_INT = int'(SRAM_LO);
    localparam int HI_INT = int'(SRAM_HI);

    always_comb begin
        can_down_o = int'(sp_i) >= (LO_INT + NEED);
        can_up_o   = int'(sp_i) <= (HI_INT - NEED);
    end
endmodule

// File: rtl/stk_range.sv
// Tells whether a candidate pointer value lies inside SRAM.
module stk_range #(
    parameter int            AW      = 16,
    parameter logic [AW-1:0] SRAM_LO = 16'h0200,
    parameter logic [AW-1:0] SRAM_HI = 16'h21FF
) (
    input  logic [AW-1:0] addr_i,
    output logic          inside_o
);
    always_comb begin
        inside_o = (addr_i >= SRAM_LO) && (addr_i <= SRAM_HI);
    end
endmodule

// File: rtl/stack_engine.sv
module stack_engine
    import stk_pkg::*;
#(
    parameter int            AW      = 16,
    parameter int            DW      = 8,
    parameter int            RIDX_W  = 5,
    parameter logic [AW-1:0] SRAM_LO = 16'h0200,
    parameter logic [AW-1:0] SRAM_HI = 16'h21FF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [RIDX_W-1:0] reg_idx,
    input  logic [DW-1:0]     push_data,
    input  logic [2*DW-1:0]   ret_in,
    input  logic              sp_we,
    input  logic [AW-1:0]     sp_wdata,
    output logic [AW-1:0]     sp,
    output logic [DW-1:0]     pop_data,
    output logic              pop_valid,
    output logic [RIDX_W-1:0] pop_idx,
    output logic [2*DW-1:0]   ret_addr,
    output logic              ret_valid,
    output logic              ovf,
    output logic              udf,
    output logic              busy,
    output logic [AW-1:0]     mem_addr,
    output logic              mem_we,
    output logic [DW-1:0]     mem_wdata,
    output logic              mem_re,
    input  logic [DW-1:0]     mem_rdata
);
    localparam int RAW      = 2 * DW;
    localparam int RA_BYTES = RAW / DW;

    typedef struct packed {
        stk_state_e        state;
        logic [AW-1:0]     sp;
        logic [DW-1:0]     ra_hi;
        logic [DW-1:0]     pop_data;
        logic              pop_valid;
        logic [RIDX_W-1:0] pop_idx;
        logic [RAW-1:0]    ret_addr;
        logic              ret_valid;
        logic              ovf;
        logic              udf;
    } stk_regs_t;

    stk_regs_t st_d, st_q;

    // Room checks for one byte (push/pop) and for a full return address.
    logic [RA_BYTES:1] can_dn, can_up;
    for (genvar g = 1; g <= RA_BYTES; g++) begin : g_room
        stk_room #(.AW(AW), .SRAM_LO(SRAM_LO), .SRAM_HI(SRAM_HI), .NEED(g)) room_i (
            .sp_i       (st_q.sp),
            .can_down_o (can_dn[g]),
            .can_up_o   (can_up[g])
        );
    end

    logic load_ok;
    stk_range #(.AW(AW), .SRAM_LO(SRAM_LO), .SRAM_HI(SRAM_HI)) load_chk_i (
        .addr_i   (sp_wdata),
        .inside_o (load_ok)
    );

    stk_op_e       op_e;
    logic [AW-1:0] sp_up, sp_dn;

    always_comb begin
        op_e      = stk_op_e'(op);
        sp_up     = st_q.sp + AW'(1);
        sp_dn     = st_q.sp - AW'(1);
        st_d      = st_q;
        st_d.pop_valid = 1'b0;
        st_d.ret_valid = 1'b0;
        mem_addr  = st_q.sp;
        mem_we    = 1'b0;
        mem_wdata = '0;
        mem_re    = 1'b0;

        unique case (st_q.state)
            ST_IDLE: begin
                if (sp_we) begin
                    if (load_ok) st_d.sp = sp_wdata;
                end else begin
                    case (op_e)
                        OP_PUSH: begin
                            st_d.ovf = !can_dn[1];
                            st_d.udf = 1'b0;
                            if (can_dn[1]) begin
                                mem_we    = 1'b1;
                                mem_wdata = push_data;
                                st_d.sp   = sp_dn;
                            end
                        end
                        OP_POP: begin
                            st_d.udf = !can_up[1];
                            st_d.ovf = 1'b0;
                            if (can_up[1]) begin
                                mem_addr       = sp_up;
                                mem_re         = 1'b1;
                                st_d.sp        = sp_up;
                                st_d.pop_data  = mem_rdata;
                                st_d.pop_idx   = reg_idx;
                                st_d.pop_valid = 1'b1;
                            end
                        end
                        OP_CALL: begin
                            st_d.ovf = !can_dn[RA_BYTES];
                            st_d.udf = 1'b0;
                            if (can_dn[RA_BYTES]) begin
                                mem_we     = 1'b1;
                                mem_wdata  = ret_in[DW-1:0];
                                st_d.ra_hi = ret_in[RAW-1:DW];
                                st_d.sp    = sp_dn;
                                st_d.state = ST_CALL_HI;
                            end
                        end
                        OP_RET: begin
                            st_d.udf = !can_up[RA_BYTES];
                            st_d.ovf = 1'b0;
                            if (can_up[RA_BYTES]) begin
                                mem_addr   = sp_up;
                                mem_re     = 1'b1;
                                st_d.ra_hi = mem_rdata;
                                st_d.sp    = sp_up;
                                st_d.state = ST_RET_LO;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_CALL_HI: begin
                mem_we     = 1'b1;
                mem_wdata  = st_q.ra_hi;
                st_d.sp    = sp_dn;
                st_d.state = ST_IDLE;
            end
            ST_RET_LO: begin
                mem_addr       = sp_up;
                mem_re         = 1'b1;
                st_d.ret_addr  = {st_q.ra_hi, mem_rdata};
                st_d.ret_valid = 1'b1;
                st_d.sp        = sp_up;
                st_d.state     = ST_IDLE;
            end
            default: st_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.state <= ST_IDLE;
            st_q.sp    <= SRAM_HI;
        end else begin
            st_q <= st_d;
        end
    end

    assign sp        = st_q.sp;
    assign pop_data  = st_q.pop_data;
    assign pop_valid = st_q.pop_valid;
    assign pop_idx   = st_q.pop_idx;
    assign ret_addr  = st_q.ret_addr;
    assign ret_valid = st_q.ret_valid;
    assign ovf       = st_q.ovf;
    assign udf       = st_q.udf;
    assign busy      = (st_q.state != ST_IDLE);

    logic idle_op;
    assign idle_op = !busy && !sp_we;

    assert_sp_in_sram_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sp >= SRAM_LO) && (sp <= SRAM_HI));

    assert_push_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_op && op == 3'd1 && sp > SRAM_LO) |=> (sp == $past(sp) - AW'(1)));

    assert_write_in_sram_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ((mem_addr >= SRAM_LO) && (mem_addr <= SRAM_HI)));

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_op && op == 3'd1 && sp == SRAM_LO) |-> !mem_we ##1 (ovf && $stable(sp)));

    assert_pop_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_op && op == 3'd2 && sp == SRAM_HI) |=> (udf && !pop_valid && sp == SRAM_HI));

    assert_call_hi_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_re) |-> mem_we);

    assert_port_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_busy_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !busy);

    assert_load_priority_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && sp_we) |-> (!mem_we && !mem_re));
endmodule

// File: tb/stack_engine_tb_top.sv
module stack_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [4:0]  reg_idx = '0;
    logic [7:0]  push_data = '0;
    logic [15:0] ret_in = '0;
    logic        sp_we = 1'b0;
    logic [15:0] sp_wdata = '0;
    logic [15:0] sp;
    logic [7:0]  pop_data;
    logic        pop_valid;
    logic [4:0]  pop_idx;
    logic [15:0] ret_addr;
    logic        ret_valid;
    logic        ovf, udf, busy;
    logic [15:0] mem_addr;
    logic        mem_we, mem_re;
    logic [7:0]  mem_wdata, mem_rdata;

    int n_checks = 0;
    int n_errors = 0;
    int wr_cnt   = 0;
    logic [7:0] ram [0:8191];

    always #5 clk = ~clk;

    stack_engine dut_i (
        .clk(clk), .rst_n(rst_n), .op(op), .reg_idx(reg_idx), .push_data(push_data),
        .ret_in(ret_in), .sp_we(sp_we), .sp_wdata(sp_wdata), .sp(sp),
        .pop_data(pop_data), .pop_valid(pop_valid), .pop_idx(pop_idx),
        .ret_addr(ret_addr), .ret_valid(ret_valid), .ovf(ovf), .udf(udf), .busy(busy),
        .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
        .mem_rdata(mem_rdata)
    );

    // Bench memory: SRAM only, asynchronous read, write on the clock edge.
    always_comb begin
        if (mem_addr >= 16'h0200 && mem_addr <= 16'h21FF) mem_rdata = ram[mem_addr - 16'h0200];
        else mem_rdata = 8'h00;
    end
    always @(posedge clk) begin
        if (mem_we) begin
            wr_cnt <= wr_cnt + 1;
            if (mem_addr >= 16'h0200 && mem_addr <= 16'h21FF) ram[mem_addr - 16'h0200] <= mem_wdata;
        end
    end

    function automatic logic [7:0] peek(input logic [15:0] a);
        return ram[a - 16'h0200];
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One cycle with the given stimulus; results are sampled 1 ns after the edge.
    task automatic cyc(input logic [2:0] o, input logic [4:0] idx, input logic [7:0] d,
                       input logic [15:0] ra, input logic we, input logic [15:0] wv);
        @(negedge clk);
        op = o; reg_idx = idx; push_data = d; ret_in = ra; sp_we = we; sp_wdata = wv;
        @(posedge clk);
        #1;
        op = 3'd0; sp_we = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1", "sp after reset", 32'(sp), 32'h21FF);
        chk("R1", "ovf after reset", 32'(ovf), 0);
        chk("R1", "udf after reset", 32'(udf), 0);
        chk("R1", "busy after reset", 32'(busy), 0);
    endtask

    task automatic t_push_pop;
        cyc(3'd1, 0, 8'hA5, 0, 0, 0);
        chk("R2", "first push byte", 32'(peek(16'h21FF)), 32'hA5);
        chk("R2", "sp after push", 32'(sp), 32'h21FE);
        cyc(3'd1, 0, 8'h3C, 0, 0, 0);
        chk("R2", "second push byte", 32'(peek(16'h21FE)), 32'h3C);
        cyc(3'd2, 5'd7, 0, 0, 0, 0);
        chk("R4", "pop data lifo", 32'(pop_data), 32'h3C);
        chk("R4", "pop idx", 32'(pop_idx), 7);
        chk("R4", "pop valid", 32'(pop_valid), 1);
        chk("R4", "sp after pop", 32'(sp), 32'h21FE);
        cyc(3'd2, 5'd19, 0, 0, 0, 0);
        chk("R4", "second pop data", 32'(pop_data), 32'hA5);
        chk("R4", "second pop idx", 32'(pop_idx), 19);
        chk("R4", "sp back at top", 32'(sp), 32'h21FF);
        cyc(3'd0, 0, 0, 0, 0, 0);
        chk("R4", "pop valid is a pulse", 32'(pop_valid), 0);
    endtask

    task automatic t_pop_underflow;
        cyc(3'd2, 5'd3, 0, 0, 0, 0);
        chk("R5", "udf on empty pop", 32'(udf), 1);
        chk("R5", "no pop valid", 32'(pop_valid), 0);
        chk("R5", "sp held", 32'(sp), 32'h21FF);
        cyc(3'd1, 0, 8'h11, 0, 0, 0);
        chk("R11", "udf cleared by push", 32'(udf), 0);
        cyc(3'd2, 5'd1, 0, 0, 0, 0);
        chk("R11", "pop ok after flag", 32'(pop_data), 32'h11);
    endtask

    task automatic t_call_ret;
        int w0;
        w0 = wr_cnt;
        cyc(3'd3, 0, 0, 16'h1234, 0, 0);
        chk("R6", "busy in second call cycle", 32'(busy), 1);
        chk("R6", "sp after first call cycle", 32'(sp), 32'h21FE);
        cyc(3'd1, 0, 8'hEE, 0, 0, 0);   // offered while busy
        chk("R6", "busy released", 32'(busy), 0);
        chk("R6", "sp after call", 32'(sp), 32'h21FD);
        chk("R6", "low byte at top", 32'(peek(16'h21FF)), 32'h34);
        chk("R6", "high byte below", 32'(peek(16'h21FE)), 32'h12);
        chk("R9", "push during busy wrote nothing", 32'(wr_cnt - w0), 2);
        cyc(3'd4, 0, 0, 0, 0, 0);
        chk("R7", "busy in second ret cycle", 32'(busy), 1);
        chk("R7", "sp after first ret cycle", 32'(sp), 32'h21FE);
        cyc(3'd2, 5'd9, 0, 0, 0, 0);    // offered while busy
        chk("R7", "ret valid", 32'(ret_valid), 1);
        chk("R7", "ret addr", 32'(ret_addr), 32'h1234);
        chk("R7", "sp after ret", 32'(sp), 32'h21FF);
        chk("R9", "pop during busy ignored", 32'(pop_valid), 0);
    endtask

    task automatic t_ret_underflow;
        cyc(3'd4, 0, 0, 0, 0, 0);
        chk("R8", "udf on empty ret", 32'(udf), 1);
        chk("R8", "no busy on empty ret", 32'(busy), 0);
        cyc(3'd1, 0, 8'h55, 0, 0, 0);
        cyc(3'd4, 0, 0, 0, 0, 0);
        chk("R8", "udf with one byte", 32'(udf), 1);
        chk("R8", "sp held on ret udf", 32'(sp), 32'h21FE);
        chk("R8", "no ret valid", 32'(ret_valid), 0);
        cyc(3'd2, 5'd2, 0, 0, 0, 0);
        chk("R11", "udf cleared by pop", 32'(udf), 0);
        chk("R4", "pop of single byte", 32'(pop_data), 32'h55);
    endtask

    task automatic t_floor;
        int w0;
        cyc(3'd0, 0, 0, 0, 1, 16'h0201);
        chk("R10", "load in range", 32'(sp), 32'h0201);
        cyc(3'd1, 0, 8'h77, 0, 0, 0);
        chk("R2", "push to 0x0200", 32'(sp), 32'h0200);
        chk("R2", "byte at 0x0201", 32'(peek(16'h0201)), 32'h77);
        w0 = wr_cnt;
        cyc(3'd1, 0, 8'h88, 0, 0, 0);
        chk("R3", "ovf at floor", 32'(ovf), 1);
        chk("R3", "sp held at floor", 32'(sp), 32'h0200);
        chk("R3", "no write at floor", 32'(wr_cnt - w0), 0);
        cyc(3'd0, 0, 0, 0, 1, 16'h0201);
        w0 = wr_cnt;
        cyc(3'd3, 0, 0, 16'hBEEF, 0, 0);
        chk("R8", "call ovf one byte room", 32'(ovf), 1);
        chk("R8", "no busy on call ovf", 32'(busy), 0);
        chk("R8", "no write on call ovf", 32'(wr_cnt - w0), 0);
        chk("R8", "sp held on call ovf", 32'(sp), 32'h0201);
        cyc(3'd0, 0, 0, 0, 1, 16'h0202);
        cyc(3'd3, 0, 0, 16'hBEEF, 0, 0);
        chk("R11", "ovf cleared by call", 32'(ovf), 0);
        cyc(3'd0, 0, 0, 0, 0, 0);
        chk("R6", "call reaches floor", 32'(sp), 32'h0200);
        chk("R6", "call low at 0x0202", 32'(peek(16'h0202)), 32'hEF);
        chk("R6", "call high at 0x0201", 32'(peek(16'h0201)), 32'hBE);
    endtask

    task automatic t_load_rules;
        int w0;
        cyc(3'd0, 0, 0, 0, 1, 16'h1000);
        cyc(3'd0, 0, 0, 0, 1, 16'h01FF);
        chk("R10", "load below sram ignored", 32'(sp), 32'h1000);
        cyc(3'd0, 0, 0, 0, 1, 16'h2200);
        chk("R10", "load above sram ignored", 32'(sp), 32'h1000);
        w0 = wr_cnt;
        cyc(3'd1, 0, 8'h99, 0, 1, 16'h0800);
        chk("R10", "load wins over push", 32'(sp), 32'h0800);
        chk("R10", "push beside load wrote nothing", 32'(wr_cnt - w0), 0);
        cyc(3'd2, 5'd4, 0, 0, 1, 16'h0300);
        chk("R10", "pop beside load ignored", 32'(pop_valid), 0);
        chk("R10", "sp from load", 32'(sp), 32'h0300);
    endtask

    bit done = 0;
    task automatic summary;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 8192; i++) ram[i] = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_push_pop();
        t_pop_underflow();
        t_call_ret();
        t_ret_underflow();
        t_floor();
        t_load_rules();
        done = 1;
        summary();
    end
endmodule